// File: doc/BRIEF.md
# Register-Direct Integer Instruction Executor

This block runs one instruction at a time from a small 32-bit two-operand integer instruction set whose operands are both registers. Each instruction is an opcode byte, optionally preceded by the two-byte escape (0x0F), and a ModR/M byte that names the operands. The block owns an eight-entry register file of 32-bit words and three condition flags: sign, zero and overflow. It computes the result, writes it back and updates the flags.

Supported work covers arithmetic (add, subtract, negate), bitwise logic (AND, OR, XOR, NOT), compare, copy, exchange, a truncating multiply into a register, a widening unsigned multiply into the accumulator pair, and increment and decrement in both the short one-byte form and the ModR/M group form. Operands in memory are out of scope. An unsupported encoding completes with an illegal-instruction indication and changes nothing. A load port fills registers before a program runs, and every register can be read at any time on a flat view bus.

A two-state machine controls the block. IDLE waits for a strobe. The transition IDLE to EXEC latches the instruction bytes. The transition EXEC to IDLE writes results and flags and pulses done. There are no other states or transitions.

Top module: `rdx_exec`

## Requirements
- R1: After reset every register reads 0, the three flags read 0, and done and illegal are 0.
- R2: A strobe sampled in IDLE is latched at that edge. Results are written and done is high for exactly one cycle after the following edge. A strobe that is still high during EXEC starts no second instruction.
- R3: The ModR/M byte is split into bits [7:6] mode, [5:3] register or sub-operation, and [2:0] register/memory operand. Register indices 0..7 are accumulator (0), counter, high-product register (2), base, stack, frame, source and destination. Every ModR/M form whose mode is not 3 is illegal.
- R4: Opcodes 0x01, 0x29, 0x21, 0x09 and 0x31 compute rm = rm OP reg for add, subtract, AND, OR and XOR respectively. All five set SF from bit 31 and ZF on a zero result. OF shows signed overflow for add and subtract and is cleared for the three logic operations.
- R5: Opcode 0x39 computes rm minus reg and writes no register. SF is set when the 32-bit difference is negative, ZF when it is zero, and OF when the 32-bit difference differs from the exact difference.
- R6: Opcode 0x89 copies reg into rm. Opcode 0x87 swaps reg and rm, and naming the same register twice leaves it unchanged. Neither changes the flags.
- R7: The escaped opcode 0x0F 0xAF writes the low 32 bits of reg times rm into the register named by the reg field, without changing the flags. Any other opcode after the escape is illegal.
- R8: Opcode 0xF7 with sub-operation 4 forms the unsigned 64-bit product of register 0 and rm. The low half goes to register 0 and the high half to register 2. OF is set exactly when the high half is nonzero, and SF and ZF are kept.
- R9: Opcode 0xF7 with sub-operation 3 replaces rm with its two's complement. SF comes from bit 31 of the result, ZF is set on zero, and OF is cleared.
- R10: Negating 0x80000000 leaves the register unchanged and sets SF=1, ZF=0 and OF=1.
- R11: Opcode 0xF7 with sub-operation 2 inverts every bit of rm. SF and ZF come from the result and OF is cleared.
- R12: Opcodes 0x40..0x47 increment, and 0x48..0x4F decrement, the register named by the opcode's bits [2:0], wrapping modulo 2^32. The ModR/M byte is ignored for these opcodes. Opcode 0xFF with sub-operation 0 increments rm and with sub-operation 1 decrements it. No increment or decrement changes the flags.
- R13: Any other opcode, 0xF7 with a sub-operation outside 2..4, and 0xFF with a sub-operation above 1 pulse done together with illegal and leave every register and flag unchanged.
- R14: A load request with load index and data, sampled in IDLE, writes that register at the edge. A load request during EXEC is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction strobe |
| issue_pfx | input | 1 | The opcode was preceded by the 0x0F escape |
| issue_opc | input | 8 | Opcode byte |
| issue_modrm | input | 8 | ModR/M byte |
| ld_en | input | 1 | Register load request |
| ld_idx | input | 3 | Register to load |
| ld_data | input | 32 | Load value |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | The completing instruction was illegal (valid with done) |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_o | output | 1 | Overflow flag |
| reg_view | output | 256 | All registers, register i at bits [32*i+31:32*i] |

## Verification
The situations hardest to reach from the ports are the single overflowing negate, which needs the operand to be exactly 0x80000000, and a widening multiply whose high half is nonzero. Uniform random operands almost never produce the first and rarely steer the second. The bench therefore preloads those exact operands through the load port before issuing the directed instructions, and then runs a seeded random mix of valid, wrong-mode and undefined encodings over registers that are reloaded from time to time with random values, including the extremes.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

    localparam int WORD_W   = 32;
    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int IDX_ACC  = 0;   // widening multiply: multiplicand and low half
    localparam int IDX_HI   = 2;   // widening multiply: high half

    localparam logic [7:0] OPC_ADD   = 8'h01;
    localparam logic [7:0] OPC_SUB   = 8'h29;
    localparam logic [7:0] OPC_AND   = 8'h21;
    localparam logic [7:0] OPC_OR    = 8'h09;
    localparam logic [7:0] OPC_XOR   = 8'h31;
    localparam logic [7:0] OPC_CMP   = 8'h39;
    localparam logic [7:0] OPC_MOV   = 8'h89;
    localparam logic [7:0] OPC_XCHG  = 8'h87;
    localparam logic [7:0] OPC_GRP3  = 8'hF7;
    localparam logic [7:0] OPC_GRP5  = 8'hFF;
    localparam logic [7:0] OPC_IMUL2 = 8'hAF;  // after the escape byte

    typedef enum logic {
        ST_IDLE,
        ST_EXEC
    } state_e;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_XOR,
        K_MOVB, K_SWAP, K_IMUL, K_UMUL,
        K_NEG, K_NOT, K_INC, K_DEC
    } alu_op_e;

    typedef enum logic [1:0] {
        FU_KEEP,   // flags untouched
        FU_ALL,    // sign, zero and overflow from the unit
        FU_OVF     // overflow only
    } flag_upd_e;

    typedef struct packed {
        alu_op_e          op;
        logic [IDX_W-1:0] a_idx;
        logic [IDX_W-1:0] b_idx;
        logic             we0;
        logic [IDX_W-1:0] wi0;
        logic             we1;
        logic [IDX_W-1:0] wi1;
        flag_upd_e        fu;
        logic             illegal;
    } dec_t;

endpackage

// File: rtl/rdx_decode.sv
module rdx_decode
    import rdx_pkg::*;
(
    input  logic       pfx,
    input  logic [7:0] opc,
    input  logic [7:0] modrm,
    output dec_t       dec
);

    logic             mode_direct;
    logic [IDX_W-1:0] fld_reg;
    logic [IDX_W-1:0] fld_rm;

    assign mode_direct = (modrm[7:6] == 2'b11);
    assign fld_reg     = modrm[5:3];
    assign fld_rm      = modrm[2:0];

    always_comb begin
        dec         = '0;
        dec.op      = K_ADD;
        dec.fu      = FU_KEEP;
        dec.a_idx   = fld_rm;
        dec.b_idx   = fld_reg;
        dec.wi0     = fld_rm;
        dec.wi1     = fld_reg;
        dec.illegal = 1'b0;
        if (pfx) begin
            if (opc == OPC_IMUL2) begin
                dec.op  = K_IMUL;
                dec.we0 = 1'b1;
                dec.wi0 = fld_reg;
            end else begin
                dec.illegal = 1'b1;
            end
            if (!mode_direct) dec.illegal = 1'b1;
        end else if (opc[7:4] == 4'h4) begin
            // short form: register in the opcode, ModR/M ignored
            dec.a_idx = opc[2:0];
            dec.wi0   = opc[2:0];
            dec.we0   = 1'b1;
            dec.op    = opc[3] ? K_DEC : K_INC;
        end else begin
            unique case (opc)
                OPC_ADD: begin dec.op = K_ADD; dec.we0 = 1'b1; dec.fu = FU_ALL; end
                OPC_SUB: begin dec.op = K_SUB; dec.we0 = 1'b1; dec.fu = FU_ALL; end
                OPC_AND: begin dec.op = K_AND; dec.we0 = 1'b1; dec.fu = FU_ALL; end
                OPC_OR:  begin dec.op = K_OR;  dec.we0 = 1'b1; dec.fu = FU_ALL; end
                OPC_XOR: begin dec.op = K_XOR; dec.we0 = 1'b1; dec.fu = FU_ALL; end
                OPC_CMP: begin dec.op = K_SUB; dec.fu = FU_ALL; end
                OPC_MOV: begin dec.op = K_MOVB; dec.we0 = 1'b1; end
                OPC_XCHG: begin
                    dec.op  = K_SWAP;
                    dec.we0 = 1'b1;
                    dec.we1 = 1'b1;
                end
                OPC_GRP3: begin
                    unique case (fld_reg)
                        3'd2: begin dec.op = K_NOT; dec.we0 = 1'b1; dec.fu = FU_ALL; end
                        3'd3: begin dec.op = K_NEG; dec.we0 = 1'b1; dec.fu = FU_ALL; end
                        3'd4: begin
                            dec.op  = K_UMUL;
                            dec.we0 = 1'b1;
                            dec.wi0 = IDX_W'(IDX_ACC);
                            dec.we1 = 1'b1;
                            dec.wi1 = IDX_W'(IDX_HI);
                            dec.fu  = FU_OVF;
                        end
                        default: dec.illegal = 1'b1;
                    endcase
                end
                OPC_GRP5: begin
                    unique case (fld_reg)
                        3'd0:    begin dec.op = K_INC; dec.we0 = 1'b1; end
                        3'd1:    begin dec.op = K_DEC; dec.we0 = 1'b1; end
                        default: dec.illegal = 1'b1;
                    endcase
                end
                default: dec.illegal = 1'b1;
            endcase
            if (!mode_direct) dec.illegal = 1'b1;
        end
    end

endmodule

// File: rtl/rdx_alu.sv
module rdx_alu
    import rdx_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,     // rm operand (or short-form register)
    input  logic [W-1:0] b,     // reg operand
    input  logic [W-1:0] acc,   // accumulator for widening multiply
    output logic [W-1:0] lo,
    output logic [W-1:0] hi,
    output logic         sf,
    output logic         zf,
    output logic         of
);

    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W:0]     sum_x;
    logic [W:0]     dif_x;
    logic [2*W-1:0] wide;
    logic [W-1:0]   prod_lo;

    // one extra sign bit exposes signed overflow as a mismatch of the top two bits
    assign sum_x   = {a[W-1], a} + {b[W-1], b};
    assign dif_x   = {a[W-1], a} - {b[W-1], b};
    assign wide    = {{W{1'b0}}, acc} * {{W{1'b0}}, a};
    assign prod_lo = a * b;

    always_comb begin
        lo = a;
        hi = '0;
        of = 1'b0;
        unique case (op)
            K_ADD:  begin lo = sum_x[W-1:0]; of = sum_x[W] ^ sum_x[W-1]; end
            K_SUB:  begin lo = dif_x[W-1:0]; of = dif_x[W] ^ dif_x[W-1]; end
            K_AND:  lo = a & b;
            K_OR:   lo = a | b;
            K_XOR:  lo = a ^ b;
            K_MOVB: lo = b;
            K_SWAP: begin lo = b; hi = a; end
            K_IMUL: lo = prod_lo;
            K_UMUL: begin lo = wide[W-1:0]; hi = wide[2*W-1:W]; of = |wide[2*W-1:W]; end
            K_NEG: begin
                if (a == MIN_NEG) begin
                    lo = a;
                    of = 1'b1;
                end else begin
                    lo = '0 - a;
                end
            end
            K_NOT:  lo = ~a;
            K_INC:  lo = a + 1'b1;
            K_DEC:  lo = a - 1'b1;
            default: lo = a;
        endcase
        sf = lo[W-1];
        zf = (lo == '0);
    end

    // R10: the sole overflowing negate keeps its operand and reports overflow
    always_comb begin
        if (op == K_NEG && a == MIN_NEG) begin
            p_neg_min_r10: assert (lo == MIN_NEG && of && sf && !zf)
                else $error("negate of most negative value misbehaved");
        end
    end

endmodule

// File: rtl/rdx_regfile.sv
module rdx_regfile
    import rdx_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int N = NUM_REGS,
    localparam int IW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_en,
    input  logic [IW-1:0]  ld_idx,
    input  logic [W-1:0]   ld_data,
    input  logic           we0,
    input  logic [IW-1:0]  wi0,
    input  logic [W-1:0]   wd0,
    input  logic           we1,
    input  logic [IW-1:0]  wi1,
    input  logic [W-1:0]   wd1,
    output logic [N*W-1:0] rd_flat
);

    for (genvar g = 0; g < N; g++) begin : g_reg
        logic [W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we1 && wi1 == IW'(g)) begin
                q <= wd1;
            end else if (we0 && wi0 == IW'(g)) begin
                q <= wd0;
            end else if (ld_en && ld_idx == IW'(g)) begin
                q <= ld_data;
            end
        end
        assign rd_flat[g*W +: W] = q;
    end

    // R6: two result ports aimed at one register must agree (exchange of a register with itself)
    always_comb begin
        if (rst_n && we0 && we1 && wi0 == wi1) begin
            p_port_agree_r6: assert (wd0 == wd1)
                else $error("write ports collide with different data");
        end
    end

endmodule

// File: rtl/rdx_exec.sv
module rdx_exec
    import rdx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue_valid,
    input  logic                     issue_pfx,
    input  logic [7:0]               issue_opc,
    input  logic [7:0]               issue_modrm,
    input  logic                     ld_en,
    input  logic [IDX_W-1:0]         ld_idx,
    input  logic [WORD_W-1:0]        ld_data,
    output logic                     done,
    output logic                     illegal,
    output logic                     flag_s,
    output logic                     flag_z,
    output logic                     flag_o,
    output logic [NUM_REGS*WORD_W-1:0] reg_view
);

    state_e state, state_nx;

    logic       pfx_q;
    logic [7:0] opc_q;
    logic [7:0] modrm_q;

    dec_t              dec;
    logic [WORD_W-1:0] opnd_a, opnd_b, opnd_acc;
    logic [WORD_W-1:0] res_lo, res_hi;
    logic              alu_s, alu_z, alu_o;
    logic              commit;
    logic              we0, we1, ld_ok;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (issue_valid) state_nx = ST_EXEC;
            ST_EXEC: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // ---------------- instruction latch ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pfx_q   <= 1'b0;
            opc_q   <= '0;
            modrm_q <= '0;
        end else if (state == ST_IDLE && issue_valid) begin
            pfx_q   <= issue_pfx;
            opc_q   <= issue_opc;
            modrm_q <= issue_modrm;
        end
    end

    rdx_decode u_dec (
        .pfx   (pfx_q),
        .opc   (opc_q),
        .modrm (modrm_q),
        .dec   (dec)
    );

    assign opnd_a   = reg_view[dec.a_idx*WORD_W +: WORD_W];
    assign opnd_b   = reg_view[dec.b_idx*WORD_W +: WORD_W];
    assign opnd_acc = reg_view[IDX_ACC*WORD_W +: WORD_W];

    rdx_alu #(.W(WORD_W)) u_alu (
        .op  (dec.op),
        .a   (opnd_a),
        .b   (opnd_b),
        .acc (opnd_acc),
        .lo  (res_lo),
        .hi  (res_hi),
        .sf  (alu_s),
        .zf  (alu_z),
        .of  (alu_o)
    );

    assign commit = (state == ST_EXEC) && !dec.illegal;
    assign we0    = commit && dec.we0;
    assign we1    = commit && dec.we1;
    assign ld_ok  = ld_en && (state == ST_IDLE);

    rdx_regfile #(.W(WORD_W), .N(NUM_REGS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_ok),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .we0     (we0),
        .wi0     (dec.wi0),
        .wd0     (res_lo),
        .we1     (we1),
        .wi1     (dec.wi1),
        .wd1     (res_hi),
        .rd_flat (reg_view)
    );

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b0;
            illegal <= 1'b0;
            flag_s  <= 1'b0;
            flag_z  <= 1'b0;
            flag_o  <= 1'b0;
        end else begin
            done    <= (state == ST_EXEC);
            illegal <= (state == ST_EXEC) && dec.illegal;
            if (commit) begin
                unique case (dec.fu)
                    FU_ALL: begin
                        flag_s <= alu_s;
                        flag_z <= alu_z;
                        flag_o <= alu_o;
                    end
                    FU_OVF:  flag_o <= alu_o;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- assertions ----------------
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done held longer than one cycle");

    p_issue_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && issue_valid) |=> ##1 done)
        else $error("accepted strobe did not complete in time");

    p_illegal_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> ($stable(reg_view) && $stable({flag_s, flag_z, flag_o})))
        else $error("illegal instruction changed state");

    p_illegal_with_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done)
        else $error("illegal raised without done");

    p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal && !pfx_q && opc_q == OPC_CMP) |-> $stable(reg_view))
        else $error("compare wrote a register");

endmodule

// File: tb/test_rdx_exec.sv
module test_rdx_exec;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue_valid = 1'b0;
    logic         issue_pfx = 1'b0;
    logic [7:0]   issue_opc = '0;
    logic [7:0]   issue_modrm = '0;
    logic         ld_en = 1'b0;
    logic [2:0]   ld_idx = '0;
    logic [31:0]  ld_data = '0;
    logic         done, illegal, flag_s, flag_z, flag_o;
    logic [255:0] reg_view;

    always #5 clk = ~clk;

    rdx_exec i_rdx_exec (
        .clk, .rst_n, .issue_valid, .issue_pfx, .issue_opc, .issue_modrm,
        .ld_en, .ld_idx, .ld_data, .done, .illegal, .flag_s, .flag_z, .flag_o,
        .reg_view
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] m_r [8];
    logic m_s, m_z, m_o;

    function automatic logic [31:0] vreg(int i);
        return reg_view[i*32 +: 32];
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag, logic exp_ill);
        check(tag, {63'd0, done}, 64'd1, "done");
        check(tag, {63'd0, illegal}, {63'd0, exp_ill}, "illegal");
        check(tag, {61'd0, flag_s, flag_z, flag_o}, {61'd0, m_s, m_z, m_o}, "flags SZO");
        for (int i = 0; i < 8; i++)
            check(tag, {32'd0, vreg(i)}, {32'd0, m_r[i]}, $sformatf("reg%0d", i));
    endtask

    // reference: flags from an exact signed result
    task automatic set_arith(logic [31:0] r32, longint exact);
        m_s = r32[31];
        m_z = (r32 == 32'd0);
        m_o = (exact != longint'($signed(r32)));
    endtask

    task automatic ref_step(logic pfx, logic [7:0] op, logic [7:0] mr, output logic ill);
        logic [2:0]  rg, rm;
        logic [31:0] a, b, r;
        logic [63:0] p;
        longint      ex;
        rg = mr[5:3];
        rm = mr[2:0];
        a = m_r[rm];
        b = m_r[rg];
        ill = 1'b0;
        if (pfx) begin
            if (op == 8'hAF && mr[7:6] == 2'b11) m_r[rg] = b * a;
            else ill = 1'b1;
        end else if (op[7:4] == 4'h4) begin
            m_r[op[2:0]] = op[3] ? m_r[op[2:0]] - 32'd1 : m_r[op[2:0]] + 32'd1;
        end else if (mr[7:6] != 2'b11) begin
            ill = 1'b1;
        end else begin
            case (op)
                8'h01: begin ex = longint'($signed(a)) + longint'($signed(b)); r = a + b; set_arith(r, ex); m_r[rm] = r; end
                8'h29: begin ex = longint'($signed(a)) - longint'($signed(b)); r = a - b; set_arith(r, ex); m_r[rm] = r; end
                8'h39: begin ex = longint'($signed(a)) - longint'($signed(b)); r = a - b; set_arith(r, ex); end
                8'h21: begin r = a & b; set_arith(r, longint'($signed(r))); m_r[rm] = r; end
                8'h09: begin r = a | b; set_arith(r, longint'($signed(r))); m_r[rm] = r; end
                8'h31: begin r = a ^ b; set_arith(r, longint'($signed(r))); m_r[rm] = r; end
                8'h89: m_r[rm] = b;
                8'h87: begin m_r[rm] = b; m_r[rg] = a; end
                8'hF7: case (rg)
                    3'd2: begin r = ~a; set_arith(r, longint'($signed(r))); m_r[rm] = r; end
                    3'd3: begin
                        if (a == 32'h8000_0000) begin m_s = 1'b1; m_z = 1'b0; m_o = 1'b1; end
                        else begin r = -a; set_arith(r, longint'($signed(r))); m_r[rm] = r; end
                    end
                    3'd4: begin
                        p = {32'd0, m_r[0]} * {32'd0, a};
                        m_r[0] = p[31:0];
                        m_r[2] = p[63:32];
                        m_o = (p[63:32] != 32'd0);
                    end
                    default: ill = 1'b1;
                endcase
                8'hFF: case (rg)
                    3'd0: m_r[rm] = a + 32'd1;
                    3'd1: m_r[rm] = a - 32'd1;
                    default: ill = 1'b1;
                endcase
                default: ill = 1'b1;
            endcase
        end
    endtask

    function automatic string tag_of(logic pfx, logic [7:0] op, logic [7:0] mr);
        if (pfx) return (op == 8'hAF && mr[7:6] == 2'b11) ? "R7" : "R13";
        if (op[7:4] == 4'h4) return "R12";
        if (mr[7:6] != 2'b11) return "R3";
        case (op)
            8'h01, 8'h29, 8'h21, 8'h09, 8'h31: return "R4";
            8'h39: return "R5";
            8'h89, 8'h87: return "R6";
            8'hF7: case (mr[5:3])
                3'd2: return "R11";
                3'd3: return "R9";
                3'd4: return "R8";
                default: return "R13";
            endcase
            8'hFF: return (mr[5:3] < 3'd2) ? "R12" : "R13";
            default: return "R13";
        endcase
    endfunction

    task automatic load(int idx, logic [31:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx[2:0]; ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
        m_r[idx] = val;
    endtask

    task automatic run_inst(logic pfx, logic [7:0] op, logic [7:0] mr, string tag);
        logic ill;
        @(negedge clk);
        issue_valid = 1'b1; issue_pfx = pfx; issue_opc = op; issue_modrm = mr;
        @(negedge clk);
        issue_valid = 1'b0;
        @(negedge clk);
        ref_step(pfx, op, mr, ill);
        check_all(tag, ill);
    endtask

    initial begin
        logic ill;
        logic [7:0] op, mr;
        logic pfx;
        int sel;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) m_r[i] = '0;
        m_s = 1'b0; m_z = 1'b0; m_o = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {63'd0, done}, 64'd0, "done at reset");
        check("R1", {63'd0, illegal}, 64'd0, "illegal at reset");
        check("R1", {61'd0, flag_s, flag_z, flag_o}, 64'd0, "flags at reset");
        check("R1", {32'd0, vreg(5)}, 64'd0, "reg5 at reset");
        rst_n = 1'b1;

        // R14: loads
        load(0, 32'h10); load(3, 32'h1);
        check("R14", {32'd0, vreg(0)}, 64'h10, "loaded reg0");
        check("R14", {32'd0, vreg(3)}, 64'h1, "loaded reg3");

        // R4: arithmetic and logic, rm=0 reg=3
        run_inst(0, 8'h01, 8'hD8, "R4");
        check("R4", {32'd0, vreg(0)}, 64'h11, "add result");
        load(0, 32'd10); run_inst(0, 8'h29, 8'hD8, "R4");
        check("R4", {32'd0, vreg(0)}, 64'd9, "sub result");
        load(0, 32'h0a0b0c0d); load(3, 32'hff); run_inst(0, 8'h21, 8'hD8, "R4");
        load(0, 32'h0a0b0c0d); load(3, 32'ha0b0c0d0); run_inst(0, 8'h09, 8'hD8, "R4");
        check("R4", {32'd0, vreg(0)}, 64'haabbccdd, "or result");
        load(0, 32'h0a0b0c0d); load(3, 32'haabbc0d0); run_inst(0, 8'h31, 8'hD8, "R4");
        load(0, 32'h7fffffff); load(3, 32'd1); run_inst(0, 8'h01, 8'hD8, "R4");
        check("R4", {63'd0, flag_o}, 64'd1, "add overflow");

        // R5: compare greater / lesser / equal / overflow
        load(0, 32'h0a0b0c0d); load(3, 32'h0a0b0c07); run_inst(0, 8'h39, 8'hD8, "R5");
        load(0, 32'h0a0b0c07); load(3, 32'h0a0b0c0d); run_inst(0, 8'h39, 8'hD8, "R5");
        check("R5", {63'd0, flag_s}, 64'd1, "cmp lesser sign");
        load(3, 32'h0a0b0c07); run_inst(0, 8'h39, 8'hD8, "R5");
        check("R5", {63'd0, flag_z}, 64'd1, "cmp equal zero");
        load(0, 32'h80000000); load(3, 32'd1); run_inst(0, 8'h39, 8'hD8, "R5");

        // R6: move, exchange, exchange with itself
        load(3, 32'haf); run_inst(0, 8'h89, 8'hD8, "R6");
        load(0, 32'h2e); run_inst(0, 8'h87, 8'hD8, "R6");
        check("R6", {32'd0, vreg(3)}, 64'h2e, "xchg reg side");
        run_inst(0, 8'h87, 8'hDB, "R6");

        // R7: escaped multiply writes the reg-field register (reg=3)
        load(0, 32'd4); load(3, 32'd2); run_inst(1, 8'hAF, 8'hD8, "R7");
        check("R7", {32'd0, vreg(3)}, 64'd8, "imul result");
        run_inst(1, 8'h01, 8'hD8, "R7");

        // R8: widening multiply, low and high product
        load(0, 32'd4); load(1, 32'd3); run_inst(0, 8'hF7, 8'hE1, "R8");
        load(0, 32'hffffffff); load(1, 32'd2); run_inst(0, 8'hF7, 8'hE1, "R8");
        check("R8", {32'd0, vreg(2)}, 64'd1, "high half");
        check("R8", {63'd0, flag_o}, 64'd1, "overflow on high half");

        // R9, R10: negate normal, zero, most negative
        load(3, 32'd1); run_inst(0, 8'hF7, 8'hDB, "R9");
        check("R9", {32'd0, vreg(3)}, 64'hffffffff, "neg result");
        load(3, 32'd0); run_inst(0, 8'hF7, 8'hDB, "R9");
        load(3, 32'h80000000); run_inst(0, 8'hF7, 8'hDB, "R10");
        check("R10", {61'd0, flag_s, flag_z, flag_o}, 64'b101, "neg overflow flags");

        // R11: invert
        load(3, 32'h0f0f00ff); run_inst(0, 8'hF7, 8'hD3, "R11");
        check("R11", {32'd0, vreg(3)}, 64'hf0f0ff00, "not result");

        // R12: short and group forms, wrap, ModR/M ignored for short form
        load(1, 32'h1f); run_inst(0, 8'h41, 8'h00, "R12");
        check("R12", {32'd0, vreg(1)}, 64'h20, "short inc");
        run_inst(0, 8'h49, 8'h3F, "R12");
        load(0, 32'hffffffff); run_inst(0, 8'hFF, 8'hC0, "R12");
        run_inst(0, 8'hFF, 8'hC8, "R12");

        // R3: non-direct mode is illegal; R13: undefined encodings
        run_inst(0, 8'h01, 8'h18, "R3");
        run_inst(0, 8'hF7, 8'h80, "R3");
        run_inst(0, 8'hF7, 8'hC0, "R13");
        run_inst(0, 8'hFF, 8'hF8, "R13");
        run_inst(0, 8'h00, 8'hC0, "R13");

        // R2: strobe held through EXEC gives a single execution
        load(5, 32'd7);
        @(negedge clk);
        issue_valid = 1'b1; issue_pfx = 1'b0; issue_opc = 8'h45; issue_modrm = 8'h00;
        @(negedge clk);
        @(negedge clk);
        issue_valid = 1'b0;
        ref_step(0, 8'h45, 8'h00, ill);
        check_all("R2", ill);
        @(negedge clk);
        check("R2", {63'd0, done}, 64'd0, "done falls");
        check("R2", {32'd0, vreg(5)}, 64'd8, "single increment");

        // R14: load during EXEC is ignored
        @(negedge clk);
        issue_valid = 1'b1; issue_opc = 8'h40; issue_modrm = 8'h00;
        @(negedge clk);
        issue_valid = 1'b0; ld_en = 1'b1; ld_idx = 3'd6; ld_data = 32'hdead;
        @(negedge clk);
        ld_en = 1'b0;
        ref_step(0, 8'h40, 8'h00, ill);
        check_all("R14", ill);

        // random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom % 5 == 0) begin
                sel = $urandom % 4;
                load($urandom % 8, sel == 0 ? 32'h80000000 : sel == 1 ? 32'hffffffff : $urandom);
            end
            sel = $urandom % 16;
            pfx = 1'b0;
            case (sel)
                0: op = 8'h01; 1: op = 8'h29; 2: op = 8'h21; 3: op = 8'h09;
                4: op = 8'h31; 5: op = 8'h39; 6: op = 8'h89; 7: op = 8'h87;
                8, 9: op = 8'hF7; 10: op = 8'hFF;
                11: op = 8'h40 | 8'($urandom % 16);
                12: begin pfx = 1'b1; op = 8'hAF; end
                13: begin pfx = 1'b1; op = 8'($urandom); end
                default: op = 8'($urandom);
            endcase
            mr = 8'($urandom);
            if ($urandom % 8 != 0) mr[7:6] = 2'b11;
            run_inst(pfx, op, mr, tag_of(pfx, op, mr));
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule